// File: doc/BRIEF.md
# APB Completion-Contract Monitor

This block sits passively beside one APB completer and watches both its bus pins and a few of its internal signals. It never drives the bus. It checks the completion contract at the causal level, not only whether the handshake is legal. A read may complete only when the completer's registered data is valid. A register write may happen only on the completing cycle. An unselected completer must not hold the ready line low. An error response on a legal access must be backed by a status bit. Every access must also finish within a programmable number of wait states.

Each rule has its own sticky flag, and only reset clears it. A single fail output is the OR of all the flags. The block can be instantiated in simulation or in prototype silicon, where it catches faults that show up only under real traffic.

Top module: `apb_contract_monitor`

## Requirements
- R1: `timeoutLimit` is the number of wait states tolerated. An access phase is a cycle with psel and penable both high. When an access-phase cycle has pready low after `timeoutLimit` earlier low access cycles of the same access, bit 0 of `ruleFlags` sets on the next clock. A limit of 0 flags the first wait state.
- R2: The wait counter returns to zero on every completing cycle (psel, penable and pready high) and on every setup cycle (psel high, penable low). It saturates at the limit. Separate accesses that each stay within the limit never set bit 0.
- R3: On a completing read (pwrite low), `slvDataValid` low sets bit 1. On a completing write, `slvDataValid` is ignored.
- R4: `slvWrEn` high in any cycle that is not a completing cycle sets bit 2. This includes setup cycles, wait states and unselected cycles.
- R5: The address is captured on each setup cycle. Any access-phase cycle whose `paddr` differs from the captured value sets bit 3. A new setup with a new address does not set bit 3.
- R6: psel low with pready low sets bit 4.
- R7: pslverr is looked at only on completing cycles. A completing cycle with pslverr high, `accessMapped` high, `accessProtOk` high and `slvStatus` all zero sets bit 5, for reads and writes alike. pslverr in a wait state, on an unmapped access, or on a protection-denied access does not set bit 5.
- R8: pready unknown while psel is high sets bit 6. Known pready values never set it.
- R9: All flags are zero after reset. Once set, a flag stays set through any later traffic until reset.
- R10: `anyFail` is high exactly when at least one bit of `ruleFlags` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset; clears all flags |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase enable |
| pready | input | 1 | Completer ready |
| pwrite | input | 1 | High for a write access |
| paddr | input | ADDR_W | Access address |
| pslverr | input | 1 | Completer error response |
| slvWrEn | input | 1 | Completer's internal register write strobe |
| slvDataValid | input | 1 | Completer's registered read-data-valid flag |
| accessMapped | input | 1 | Address falls in a mapped register |
| accessProtOk | input | 1 | Access passes protection |
| slvStatus | input | STATUS_W | Completer error status bits |
| timeoutLimit | input | CNT_W | Wait states tolerated before a hang is flagged |
| ruleFlags | output | 7 | Sticky violation flags, bit positions as in R1 to R8 |
| anyFail | output | 1 | OR of all flags |

## Verification
The embedded properties assume a synchronous reset and a timeout limit that does not change in the middle of an access. They also assume that internal strobes such as `slvWrEn` are sampled on the same edge as the bus pins. The stimulus changes every input only on the falling clock edge and holds `timeoutLimit` constant across each access. The idle state is psel low with pready high, so any flag seen in a check comes from that check's own cycle and not from the cycles around it. An unknown pready cannot be produced by a two-state simulator, so the bench can only confirm that bit 6 stays clear for known values.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

  localparam int RULE_HANG    = 0;
  localparam int RULE_RDVALID = 1;
  localparam int RULE_COMMIT  = 2;
  localparam int RULE_ADDR    = 3;
  localparam int RULE_IDLE    = 4;
  localparam int RULE_ERRBACK = 5;
  localparam int RULE_XREADY  = 6;
  localparam int RULE_COUNT   = 7;

  // Phase strobes decoded by control, consumed by datapath
  typedef struct packed {
    logic setup;
    logic access;
    logic waiting;
    logic complete;
  } busStrobes_t;

endpackage

// File: rtl/apb_mon_datapath.sv
module apb_mon_datapath
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  timeoutLimit,
  output logic              waitExpired,
  output logic              addrDrift
);

  logic [CNT_W-1:0]  waitCnt;
  logic [ADDR_W-1:0] addrHold;

  // Wait-state counter: cleared at setup and completion, saturates at limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobes.setup || strobes.complete) begin
      waitCnt <= '0;
    end else if (strobes.waiting && (waitCnt < timeoutLimit)) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign waitExpired = strobes.waiting && (waitCnt >= timeoutLimit);

  // Address captured during setup, compared on every access-phase cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHold <= '0;
    end else if (strobes.setup) begin
      addrHold <= paddr;
    end
  end

  assign addrDrift = strobes.access && (paddr != addrHold);

  p_wait_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setup || strobes.complete) |=> (waitCnt == '0));

  p_wait_sat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.waiting && (waitCnt >= timeoutLimit) && $stable(timeoutLimit))
      |=> (waitCnt == $past(waitCnt)) || strobes.setup || strobes.complete
          || !$stable(timeoutLimit) || (waitCnt == '0));

  p_addr_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setup |=> (addrHold == $past(paddr)));

endmodule

// File: rtl/apb_mon_control.sv
module apb_mon_control
  import apb_mon_pkg::*;
#(
  parameter int STATUS_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pready,
  input  logic                  pwrite,
  input  logic                  pslverr,
  input  logic                  slvWrEn,
  input  logic                  slvDataValid,
  input  logic                  accessMapped,
  input  logic                  accessProtOk,
  input  logic [STATUS_W-1:0]   slvStatus,
  input  logic                  waitExpired,
  input  logic                  addrDrift,
  output busStrobes_t           strobes,
  output logic [RULE_COUNT-1:0] ruleFlags
);

  logic [RULE_COUNT-1:0] ruleHit;

  always_comb begin
    strobes.setup    = psel && !penable;
    strobes.access   = psel && penable;
    strobes.waiting  = psel && penable && !pready;
    strobes.complete = psel && penable && pready;
  end

  always_comb begin
    ruleHit               = '0;
    ruleHit[RULE_HANG]    = waitExpired;
    ruleHit[RULE_RDVALID] = strobes.complete && !pwrite && !slvDataValid;
    ruleHit[RULE_COMMIT]  = slvWrEn && !strobes.complete;
    ruleHit[RULE_ADDR]    = addrDrift;
    ruleHit[RULE_IDLE]    = !psel && !pready;
    ruleHit[RULE_ERRBACK] = strobes.complete && pslverr && accessMapped
                            && accessProtOk && (slvStatus == '0);
    ruleHit[RULE_XREADY]  = psel && $isunknown(pready);
  end

  // Sticky flags, cleared only by reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ruleFlags <= '0;
    end else begin
      ruleFlags <= ruleFlags | ruleHit;
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((ruleFlags & $past(ruleFlags)) == $past(ruleFlags)));

  p_ready_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && pready && !pwrite && !slvDataValid) |=> ruleFlags[RULE_RDVALID]);

  p_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (slvWrEn && !(psel && penable && pready)) |=> ruleFlags[RULE_COMMIT]);

  p_idle_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!psel && !pready) |=> ruleFlags[RULE_IDLE]);

endmodule

// File: rtl/apb_contract_monitor.sv
module apb_contract_monitor
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int STATUS_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pready,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic                  pslverr,
  input  logic                  slvWrEn,
  input  logic                  slvDataValid,
  input  logic                  accessMapped,
  input  logic                  accessProtOk,
  input  logic [STATUS_W-1:0]   slvStatus,
  input  logic [CNT_W-1:0]      timeoutLimit,
  output logic [RULE_COUNT-1:0] ruleFlags,
  output logic                  anyFail
);

  busStrobes_t strobes;
  logic        waitExpired;
  logic        addrDrift;

  apb_mon_control #(.STATUS_W(STATUS_W)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .psel         (psel),
    .penable      (penable),
    .pready       (pready),
    .pwrite       (pwrite),
    .pslverr      (pslverr),
    .slvWrEn      (slvWrEn),
    .slvDataValid (slvDataValid),
    .accessMapped (accessMapped),
    .accessProtOk (accessProtOk),
    .slvStatus    (slvStatus),
    .waitExpired  (waitExpired),
    .addrDrift    (addrDrift),
    .strobes      (strobes),
    .ruleFlags    (ruleFlags)
  );

  apb_mon_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .paddr        (paddr),
    .timeoutLimit (timeoutLimit),
    .waitExpired  (waitExpired),
    .addrDrift    (addrDrift)
  );

  assign anyFail = |ruleFlags;

  p_fail_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyFail) |-> ($past(ruleFlags) == '0));

endmodule

// File: tb/apb_contract_monitor_bench.sv
`timescale 1ns/1ps
module apb_contract_monitor_bench;

  localparam int ADDR_W = 12;
  localparam int STATUS_W = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel, penable, pready, pwrite, pslverr;
  logic slvWrEn, slvDataValid, accessMapped, accessProtOk;
  logic [ADDR_W-1:0] paddr;
  logic [STATUS_W-1:0] slvStatus;
  logic [CNT_W-1:0] timeoutLimit;
  logic [6:0] ruleFlags;
  logic anyFail;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  apb_contract_monitor u_apb_contract_monitor (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pready(pready),
    .pwrite(pwrite), .paddr(paddr), .pslverr(pslverr), .slvWrEn(slvWrEn),
    .slvDataValid(slvDataValid), .accessMapped(accessMapped),
    .accessProtOk(accessProtOk), .slvStatus(slvStatus),
    .timeoutLimit(timeoutLimit), .ruleFlags(ruleFlags), .anyFail(anyFail)
  );

  typedef struct packed {
    logic sel, en, rdy, wr, wrEn, dv, mapped, protOk, err;
    logic [7:0] status;
    logic [6:0] expFlags;
  } vec_t;

  // bit0 hang, bit1 read-valid, bit2 commit, bit3 addr, bit4 idle, bit5 error backing, bit6 unknown ready
  localparam vec_t VECS [14] = '{
    '{1,1,1,0,0,1,1,1,0, 8'h00, 7'h00},  // R3 good read
    '{1,1,1,0,0,0,1,1,0, 8'h00, 7'h02},  // R3 read without valid
    '{1,1,1,1,1,0,1,1,0, 8'h00, 7'h00},  // R4 write commits at completion
    '{1,1,0,1,1,0,1,1,0, 8'h00, 7'h04},  // R4 commit during wait
    '{0,0,1,0,1,0,1,1,0, 8'h00, 7'h04},  // R4 commit while unselected
    '{0,0,0,0,0,0,1,1,0, 8'h00, 7'h10},  // R6 idle stall
    '{1,1,1,0,0,1,1,1,1, 8'h01, 7'h00},  // R7 error backed by status
    '{1,1,1,0,0,1,1,1,1, 8'h00, 7'h20},  // R7 unbacked error
    '{1,1,1,0,0,1,0,1,1, 8'h00, 7'h00},  // R7 unmapped access
    '{1,1,1,0,0,1,1,0,1, 8'h00, 7'h00},  // R7 protection denied
    '{1,1,0,0,0,1,1,1,1, 8'h00, 7'h00},  // R7 error in wait state ignored
    '{1,1,1,1,0,0,1,1,1, 8'h00, 7'h20},  // R7 unbacked write error
    '{1,1,1,1,0,0,1,1,0, 8'h00, 7'h00},  // R3 write ignores data valid, R8 known ready
    '{1,0,1,0,1,0,1,1,0, 8'h00, 7'h04}   // R4 commit during setup
  };

  task automatic idleBus();
    psel = 0; penable = 0; pready = 1; pwrite = 0; pslverr = 0;
    slvWrEn = 0; slvDataValid = 0; accessMapped = 1; accessProtOk = 1;
    slvStatus = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    idleBus();
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic checkFlags(string req, logic [6:0] exp);
    total++;
    if (ruleFlags !== exp || anyFail !== (|exp)) begin
      fails++;
      $display("FAIL %s flags=%b anyFail=%b expected flags=%b anyFail=%b",
               req, ruleFlags, anyFail, exp, |exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idleBus();
    paddr = '0;
    timeoutLimit = 8'd4;
    doReset();
    checkFlags("R9 reset state", 7'h00);

    // Vector table: one stimulus cycle after a fresh reset
    for (int i = 0; i < 14; i++) begin
      doReset();
      psel = VECS[i].sel; penable = VECS[i].en; pready = VECS[i].rdy;
      pwrite = VECS[i].wr; slvWrEn = VECS[i].wrEn; slvDataValid = VECS[i].dv;
      accessMapped = VECS[i].mapped; accessProtOk = VECS[i].protOk;
      pslverr = VECS[i].err; slvStatus = VECS[i].status;
      @(negedge clk);
      idleBus();
      checkFlags($sformatf("R3/R4/R6/R7/R8/R10 vector %0d", i), VECS[i].expFlags);
    end

    // R1: limit 3, three wait states allowed, fourth flags
    doReset();
    timeoutLimit = 8'd3;
    psel = 1; penable = 0; pready = 0; slvDataValid = 1;
    @(negedge clk);
    penable = 1;
    repeat (3) @(negedge clk);
    checkFlags("R1 within limit", 7'h00);
    @(negedge clk);
    checkFlags("R1 hang after limit", 7'h01);
    pready = 1;
    @(negedge clk);
    idleBus();
    // R9 sticky through clean traffic
    repeat (5) @(negedge clk);
    checkFlags("R9 flag sticky", 7'h01);
    doReset();
    checkFlags("R9 cleared by reset", 7'h00);

    // R1: zero limit flags first wait state
    timeoutLimit = 8'd0;
    psel = 1; penable = 0; pready = 1; slvDataValid = 1;
    @(negedge clk);
    penable = 1; pready = 0;
    @(negedge clk);
    checkFlags("R1 zero limit", 7'h01);
    idleBus();

    // R2: counter clears at completion
    doReset();
    timeoutLimit = 8'd2;
    slvDataValid = 1;
    for (int a = 0; a < 3; a++) begin
      psel = 1; penable = 0; pready = 0;
      @(negedge clk);
      penable = 1;
      repeat (2) @(negedge clk);
      pready = 1;
      @(negedge clk);
    end
    idleBus();
    @(negedge clk);
    checkFlags("R2 clear at completion", 7'h00);

    // R2: counter clears at new setup without completion
    psel = 1; penable = 0; pready = 0; slvDataValid = 1;
    @(negedge clk);
    penable = 1;
    repeat (2) @(negedge clk);
    penable = 0;
    @(negedge clk);
    penable = 1;
    repeat (2) @(negedge clk);
    pready = 1;
    @(negedge clk);
    idleBus();
    checkFlags("R2 clear at setup", 7'h00);

    // R5: stable address, then back-to-back access with new address
    doReset();
    timeoutLimit = 8'd4;
    slvDataValid = 1;
    psel = 1; penable = 0; pready = 0; paddr = 12'h0A4;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    pready = 1;
    @(negedge clk);
    penable = 0; pready = 0; paddr = 12'h3F0;
    @(negedge clk);
    penable = 1; pready = 1;
    @(negedge clk);
    idleBus();
    checkFlags("R5 stable addresses", 7'h00);

    // R5: address drifts during wait state
    psel = 1; penable = 0; pready = 0; paddr = 12'h010; slvDataValid = 1;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    paddr = 12'h014;
    @(negedge clk);
    pready = 1;
    @(negedge clk);
    idleBus();
    checkFlags("R5 address drift", 7'h08);

    // R10 and R9: two rules accumulate
    psel = 0; pready = 0;
    @(negedge clk);
    idleBus();
    checkFlags("R10 combined flags", 7'h18);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule